// File: doc/BRIEF.md
# PLL Divider Search Engine

This block walks the legal pre-divider (N) and multiplier (M) settings of a clock synthesizer and hands them out one at a time. Each candidate carries N, M, the internal reference frequency and the oscillator frequency. The caller gives the input clock frequency, the window allowed for the internal reference, an optional output window, the oscillator ceiling and the largest N and M codes. A start pulse captures all of these values.

Each candidate is offered on a valid/ready handshake together with an accept bit. An outside judge looks at the candidate and takes it with `cand_accept` high or passes on it with `cand_accept` low. The search stops at the first candidate taken and raises `found`. If every setting has been offered and none was taken, it stops with `found` low. All divisions run through one shared multi-cycle restoring divider.

Top module: `pll_div_search`

## Requirements
- R1: The first N tried is the larger of 1 and ceil(fin_hz / fint_hi).
- R2: The last N tried is the smaller of floor(fin_hz / fint_lo) and n_cap.
- R3: For each N, the candidate's internal frequency cand_fint equals floor(fin_hz / N).
- R4: For each N, the first M is the larger of 1 and ceil(ceil(fout_lo / fint) / 2).
- R5: For each N, the last M is the smallest of floor(floor(fout_hi / fint) / 2), floor(floor(fdco_hi / fint) / 2) and m_cap.
- R6: cand_fdco equals 2 × cand_m × cand_fint, with no truncation.
- R7: fout_hi = 0 means no upper output limit. The block treats it as the all-ones value.
- R8: N is the outer loop and M the inner loop, and both count upward. A handshake with cand_accept=1 ends the search with done and found=1. When both ranges run out, done pulses with found=0. No candidate follows one that was taken.
- R9: When a range's first value is greater than its last value, that range produces no candidate. When the N range is empty, or every M range is empty, done pulses with found=0 and no candidate is offered.
- R10: A division by zero gives an all-ones quotient and a remainder equal to the dividend, so the search always ends.
- R11: start is only honoured while busy is low, and it captures every input. Changes to the inputs during a search have no effect on it. busy is high from the cycle after start until the cycle in which done pulses for one cycle.
- R12: While cand_valid is high and cand_ready is low, the candidate fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search; captures all inputs |
| fin_hz | input | FW | Input clock frequency |
| fint_lo | input | FW | Lowest allowed internal frequency |
| fint_hi | input | FW | Highest allowed internal frequency |
| fout_lo | input | FW | Lowest oscillator frequency wanted |
| fout_hi | input | FW | Highest oscillator frequency wanted (0 = no limit) |
| fdco_hi | input | FW | Oscillator hardware ceiling |
| n_cap | input | NW | Largest pre-divider code |
| m_cap | input | MW | Largest multiplier code |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | A candidate was accepted; held until the next start |
| cand_valid | output | 1 | Candidate on offer |
| cand_ready | input | 1 | Judge has a verdict this cycle |
| cand_accept | input | 1 | Verdict: 1 takes the candidate |
| cand_n | output | NW | Candidate pre-divider |
| cand_m | output | MW | Candidate multiplier |
| cand_fint | output | FW | Candidate internal frequency |
| cand_fdco | output | FW+MW+1 | Candidate oscillator frequency |

## Verification
The bench goes after the ceiling roundings at both range starts. A design that used a floor there would begin one N or M too low and offer settings outside the window. A zero reference ceiling exercises the divide-by-zero path: a divider that hung or returned zero would stall the search or sweep N from 1. Empty M ranges must be skipped silently, because a wrong comparison emits stray candidates or never advances N. Cases with fout_hi = 0 and with inputs scrambled after start catch a design that uses the zero as a real limit or reads live inputs. Random hold-off on cand_ready catches fields that drift while on offer.

// File: rtl/pll_search_pkg.sv
// Shared state encoding for the PLL divider search engine.
package pll_search_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NFIRST,
        ST_NLAST,
        ST_NCHK,
        ST_FINT,
        ST_MFIRST,
        ST_MHI,
        ST_MDCO,
        ST_MCHK,
        ST_OFFER
    } srch_state_t;
endpackage

// File: rtl/pll_div_restoring.sv
// Unsigned restoring divider, one quotient bit per cycle (W cycles).
// Assumes: go is only raised while no division is running.
// A zero divisor returns an all-ones quotient and remainder = dividend after one cycle.
module pll_div_restoring #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic          run;
    logic [CW-1:0] cnt;
    logic [W-1:0]  dvs;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        shifted = {rem, quo[W-1]};
        trial   = shifted - {1'b0, dvs};
    end

    // Load, iterate and finish a division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            dvs  <= '0;
            quo  <= '0;
            rem  <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                if (divisor == '0) begin
                    quo  <= '1;
                    rem  <= dividend;
                    done <= 1'b1;
                end else begin
                    run <= 1'b1;
                    cnt <= CW'(W);
                    quo <= dividend;
                    rem <= '0;
                    dvs <= divisor;
                end
            end else if (run) begin
                if (!trial[W]) begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= shifted[W-1:0];
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    p_div_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && divisor == '0) |=> (done && quo == '1));
    p_go_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !run);
endmodule

// File: rtl/pll_bound_pick.sv
// Smallest of three unsigned values; used to clamp range ends.
module pll_bound_pick #(
    parameter int W = 33
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    logic [W-1:0] ab;

    // Pairwise minimum, then against the third value.
    always_comb begin
        ab = (a < b) ? a : b;
        y  = (ab < c) ? ab : c;
    end
endmodule

// File: rtl/pll_div_search.sv
// PLL divider search engine: walks N (outer) and M (inner) upward and offers
// each legal setting on a valid/ready handshake until one is accepted.
// Assumes: the judge holds cand_accept valid whenever cand_ready is high.
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int FW = 32,
    parameter int NW = 8,
    parameter int MW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FW-1:0]      fin_hz,
    input  logic [FW-1:0]      fint_lo,
    input  logic [FW-1:0]      fint_hi,
    input  logic [FW-1:0]      fout_lo,
    input  logic [FW-1:0]      fout_hi,
    input  logic [FW-1:0]      fdco_hi,
    input  logic [NW-1:0]      n_cap,
    input  logic [MW-1:0]      m_cap,
    output logic               busy,
    output logic               done,
    output logic               found,
    output logic               cand_valid,
    input  logic               cand_ready,
    input  logic               cand_accept,
    output logic [NW-1:0]      cand_n,
    output logic [MW-1:0]      cand_m,
    output logic [FW-1:0]      cand_fint,
    output logic [FW+MW:0]     cand_fdco
);
    localparam int XW  = FW + 1;
    localparam int FDW = FW + MW + 1;

    srch_state_t state;
    logic [FW-1:0] fin_q, filo_q, fihi_q, folo_q, fohi_q, fdco_q;
    logic [NW-1:0] ncap_q;
    logic [MW-1:0] mcap_q;
    logic [XW-1:0] n_cur, n_last, m_cur, m_last, m_hi;
    logic [FW-1:0] fint_r;
    logic          div_pend, div_go, div_done, div_state;
    logic [FW-1:0] div_a, div_b, div_q, div_r;
    logic [XW-1:0] ceil_x, q_half, n_min, m_min;
    logic [XW:0]   half_up;
    logic [FDW-1:0] prod;

    // Choose divider operands for the current step.
    always_comb begin
        div_state = 1'b1;
        div_a     = fin_q;
        div_b     = fint_r;
        unique case (state)
            ST_NFIRST: div_b = fihi_q;
            ST_NLAST:  div_b = filo_q;
            ST_FINT:   div_b = n_cur[FW-1:0];
            ST_MFIRST: div_a = folo_q;
            ST_MHI:    div_a = fohi_q;
            ST_MDCO:   div_a = fdco_q;
            default:   div_state = 1'b0;
        endcase
        div_go = div_state && !div_pend;
    end

    // Rounding helpers on the divider result.
    always_comb begin
        ceil_x  = {1'b0, div_q} + XW'(div_r != '0);
        half_up = {1'b0, ceil_x} + (XW+1)'(1);
        q_half  = XW'(div_q >> 1);
    end

    pll_div_restoring #(.W(FW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quo      (div_q),
        .rem      (div_r)
    );

    pll_bound_pick #(.W(XW)) u_nmin (
        .a (XW'(div_q)),
        .b (XW'(ncap_q)),
        .c ({XW{1'b1}}),
        .y (n_min)
    );

    pll_bound_pick #(.W(XW)) u_mmin (
        .a (m_hi),
        .b (q_half),
        .c (XW'(mcap_q)),
        .y (m_min)
    );

    // Search sequencer: capture, range set-up, candidate offer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            div_pend <= 1'b0;
            done     <= 1'b0;
            found    <= 1'b0;
            fin_q    <= '0;
            filo_q   <= '0;
            fihi_q   <= '0;
            folo_q   <= '0;
            fohi_q   <= '0;
            fdco_q   <= '0;
            ncap_q   <= '0;
            mcap_q   <= '0;
            n_cur    <= '0;
            n_last   <= '0;
            m_cur    <= '0;
            m_last   <= '0;
            m_hi     <= '0;
            fint_r   <= '0;
        end else begin
            done <= 1'b0;
            if (div_go) begin
                div_pend <= 1'b1;
            end else if (div_done) begin
                div_pend <= 1'b0;
            end
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        fin_q  <= fin_hz;
                        filo_q <= fint_lo;
                        fihi_q <= fint_hi;
                        folo_q <= fout_lo;
                        fohi_q <= (fout_hi == '0) ? '1 : fout_hi;
                        fdco_q <= fdco_hi;
                        ncap_q <= n_cap;
                        mcap_q <= m_cap;
                        found  <= 1'b0;
                        state  <= ST_NFIRST;
                    end
                end
                ST_NFIRST: if (div_pend && div_done) begin
                    n_cur <= (ceil_x == '0) ? XW'(1) : ceil_x;
                    state <= ST_NLAST;
                end
                ST_NLAST: if (div_pend && div_done) begin
                    n_last <= n_min;
                    state  <= ST_NCHK;
                end
                ST_NCHK: begin
                    if (n_cur > n_last) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_FINT;
                    end
                end
                ST_FINT: if (div_pend && div_done) begin
                    fint_r <= div_q;
                    state  <= ST_MFIRST;
                end
                ST_MFIRST: if (div_pend && div_done) begin
                    m_cur <= (half_up[XW:1] == '0) ? XW'(1) : half_up[XW:1];
                    state <= ST_MHI;
                end
                ST_MHI: if (div_pend && div_done) begin
                    m_hi  <= q_half;
                    state <= ST_MDCO;
                end
                ST_MDCO: if (div_pend && div_done) begin
                    m_last <= m_min;
                    state  <= ST_MCHK;
                end
                ST_MCHK: begin
                    if (m_cur > m_last) begin
                        n_cur <= n_cur + 1'b1;
                        state <= ST_NCHK;
                    end else begin
                        state <= ST_OFFER;
                    end
                end
                ST_OFFER: begin
                    if (cand_ready) begin
                        if (cand_accept) begin
                            found <= 1'b1;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            m_cur <= m_cur + 1'b1;
                            state <= ST_MCHK;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Candidate outputs come straight from the loop registers.
    always_comb begin
        busy       = (state != ST_IDLE);
        cand_valid = (state == ST_OFFER);
        cand_n     = n_cur[NW-1:0];
        cand_m     = m_cur[MW-1:0];
        cand_fint  = fint_r;
        prod       = FDW'(m_cur[MW-1:0]) * FDW'(fint_r);
        cand_fdco  = {prod[FDW-2:0], 1'b0};
    end

    p_hold_cand_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && !cand_ready) |=> (cand_valid && $stable(cand_n) && $stable(cand_m)
                                         && $stable(cand_fint) && $stable(cand_fdco)));
    p_m_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (m_cur >= XW'(1) && m_cur <= m_last));
    p_n_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (n_cur >= XW'(1) && n_cur <= n_last && n_cur <= XW'(ncap_q)));
    p_no_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_ready) |=> !cand_valid);
    p_found_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> done);
    p_busy_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/pll_div_search_bench.sv
module pll_div_search_bench;
    localparam int FW  = 32;
    localparam int NW  = 8;
    localparam int MW  = 12;
    localparam int FDW = FW + MW + 1;
    localparam int MAXC = 2048;
    localparam longint unsigned ALL1 = 64'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [FW-1:0] fin_hz = '0, fint_lo = '0, fint_hi = '0;
    logic [FW-1:0] fout_lo = '0, fout_hi = '0, fdco_hi = '0;
    logic [NW-1:0] n_cap = '0;
    logic [MW-1:0] m_cap = '0;
    logic busy, done, found, cand_valid;
    logic cand_ready = 1'b0, cand_accept = 1'b0;
    logic [NW-1:0]  cand_n;
    logic [MW-1:0]  cand_m;
    logic [FW-1:0]  cand_fint;
    logic [FDW-1:0] cand_fdco;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    longint unsigned exp_n [MAXC];
    longint unsigned exp_m [MAXC];
    longint unsigned exp_f [MAXC];

    always #4 clk = ~clk;

    pll_div_search #(.FW(FW), .NW(NW), .MW(MW)) u_pll_div_search (
        .clk(clk), .rst_n(rst_n), .start(start),
        .fin_hz(fin_hz), .fint_lo(fint_lo), .fint_hi(fint_hi),
        .fout_lo(fout_lo), .fout_hi(fout_hi), .fdco_hi(fdco_hi),
        .n_cap(n_cap), .m_cap(m_cap),
        .busy(busy), .done(done), .found(found),
        .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_accept(cand_accept),
        .cand_n(cand_n), .cand_m(cand_m), .cand_fint(cand_fint), .cand_fdco(cand_fdco)
    );

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint unsigned act,
                         input longint unsigned exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint unsigned qdiv(longint unsigned a, longint unsigned b);
        return (b == 0) ? ALL1 : a / b;
    endfunction

    function automatic longint unsigned rdiv(longint unsigned a, longint unsigned b);
        return (b == 0) ? a : a % b;
    endfunction

    function automatic longint unsigned lmin(longint unsigned a, longint unsigned b);
        return (a < b) ? a : b;
    endfunction

    // Reference enumeration of all candidates, in offer order.
    task automatic model(input longint unsigned fin, filo, fihi, folo, fohi, fdco,
                         input longint unsigned ncap, mcap, output int cnt);
        longint unsigned n1, n2, f, c, m1, m2, ohi;
        cnt = 0;
        ohi = (fohi == 0) ? ALL1 : fohi;
        n1 = qdiv(fin, fihi) + ((rdiv(fin, fihi) != 0) ? 1 : 0);
        if (n1 == 0) n1 = 1;
        n2 = lmin(qdiv(fin, filo), ncap);
        for (longint unsigned n = n1; n <= n2; n++) begin
            f  = fin / n;
            c  = qdiv(folo, f) + ((rdiv(folo, f) != 0) ? 1 : 0);
            m1 = (c + 1) >> 1;
            if (m1 == 0) m1 = 1;
            m2 = lmin(lmin(qdiv(ohi, f) >> 1, qdiv(fdco, f) >> 1), mcap);
            for (longint unsigned m = m1; m <= m2; m++) begin
                if (cnt < MAXC) begin
                    exp_n[cnt] = n;
                    exp_m[cnt] = m;
                    exp_f[cnt] = f;
                end
                cnt++;
            end
        end
    endtask

    // One search: drive inputs, play the judge, compare every candidate.
    task automatic run_case(input longint unsigned fin, filo, fihi, folo, fohi, fdco,
                            input longint unsigned ncap, mcap, input int acc,
                            input bit scramble);
        int cnt, idx, hold;
        bit fresh, exp_found, busy_seen;
        logic [NW-1:0] sn;
        logic [MW-1:0] sm;
        logic [FW-1:0] sf;
        logic [FDW-1:0] sd;
        model(fin, filo, fihi, folo, fohi, fdco, ncap, mcap, cnt);
        @(negedge clk);
        fin_hz = FW'(fin); fint_lo = FW'(filo); fint_hi = FW'(fihi);
        fout_lo = FW'(folo); fout_hi = FW'(fohi); fdco_hi = FW'(fdco);
        n_cap = NW'(ncap); m_cap = MW'(mcap);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            // R11: inputs changed mid-search must not alter the result.
            fin_hz = $urandom; fint_lo = $urandom; fint_hi = $urandom;
            fout_lo = $urandom; fout_hi = $urandom; fdco_hi = $urandom;
            n_cap = NW'($urandom); m_cap = MW'($urandom);
        end
        check(busy == 1'b1, "R11 busy after start", busy, 1);
        idx = 0; hold = 0; fresh = 1'b1; busy_seen = 1'b0;
        sn = '0; sm = '0; sf = '0; sd = '0;
        forever begin
            @(negedge clk);
            cand_ready = 1'b0;
            cand_accept = 1'b0;
            if (done) break;
            if (cand_valid) begin
                if (fresh) begin
                    sn = cand_n; sm = cand_m; sf = cand_fint; sd = cand_fdco;
                    hold = $urandom % 3;
                    fresh = 1'b0;
                    if (!busy_seen) begin
                        check(busy == 1'b1, "R11 busy while offering", busy, 1);
                        busy_seen = 1'b1;
                    end
                end else begin
                    check(cand_n == sn && cand_m == sm && cand_fint == sf && cand_fdco == sd,
                          "R12 candidate held", cand_m, sm);
                end
                if (hold > 0) begin
                    hold--;
                end else begin
                    if (idx < cnt && idx < MAXC) begin
                        check(cand_n == NW'(exp_n[idx]), "R1 R2 R8 cand_n", cand_n, exp_n[idx]);
                        check(cand_m == MW'(exp_m[idx]), "R4 R5 R8 cand_m", cand_m, exp_m[idx]);
                        check(cand_fint == FW'(exp_f[idx]), "R3 cand_fint", cand_fint, exp_f[idx]);
                        check(64'(cand_fdco) == 2 * exp_m[idx] * exp_f[idx], "R6 cand_fdco",
                              64'(cand_fdco), 2 * exp_m[idx] * exp_f[idx]);
                    end else begin
                        check(1'b0, "R9 unexpected candidate", idx, cnt);
                    end
                    cand_ready = 1'b1;
                    cand_accept = (idx == acc);
                    idx++;
                    fresh = 1'b1;
                end
            end
        end
        exp_found = (acc >= 0 && acc < cnt);
        check(found == exp_found, "R8 found flag", found, exp_found);
        check(idx == (exp_found ? acc + 1 : cnt), "R8 R9 candidates offered",
              idx, exp_found ? acc + 1 : cnt);
        check(busy == 1'b0, "R11 busy low at done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R11 done one cycle", done, 0);
    endtask

    initial begin
        longint unsigned fin, fihi, filo, folo, fohi, fdco, ncap, mcap;
        int acc, cnt;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && cand_valid == 1'b0, "R11 reset idle", busy, 0);
        check(done == 1'b0 && found == 1'b0, "R8 reset flags", found, 0);
        rst_n = 1'b1;

        // R10: zero reference ceiling -> first N huge -> empty, not found.
        run_case(27000, 1000, 0, 0, 0, 2000000, 10, 30, 0, 1'b0);
        // R10: zero reference floor -> last N is n_cap.
        run_case(24000, 0, 12000, 0, 0, 200000, 4, 5, -1, 1'b0);
        // R7: fout_hi of zero is no limit; oscillator ceiling decides.
        run_case(20000, 4000, 10000, 0, 0, 300000, 5, 40, -1, 1'b0);
        // R9: output floor above every reachable oscillator frequency.
        run_case(20000, 4000, 10000, 5000000, 0, 300000, 5, 40, 0, 1'b0);
        // R1 R4: ceil rounding at both range starts; accept the first offer.
        run_case(10001, 1000, 3333, 10001, 60000, 90000, 12, 25, 0, 1'b0);
        // R11: scrambled inputs after start.
        run_case(30000, 3000, 9000, 20000, 120000, 150000, 9, 20, 7, 1'b1);

        for (int t = 0; t < 22; t++) begin
            fin  = 10000 + $urandom % 90000;
            fihi = fin / (1 + $urandom % 3);
            filo = fihi / (2 + $urandom % 6);
            ncap = 1 + $urandom % 12;
            mcap = 1 + $urandom % 30;
            folo = ($urandom % 2) ? 0 : fihi * ($urandom % 10);
            fohi = ($urandom % 4 == 0) ? 0 : folo + fihi * ($urandom % 40);
            fdco = fihi * ($urandom % 60);
            model(fin, filo, fihi, folo, fohi, fdco, ncap, mcap, cnt);
            acc = ($urandom % 4 == 0 || cnt == 0) ? -1 : int'($urandom % cnt);
            run_case(fin, filo, fihi, folo, fohi, fdco, ncap, mcap, acc, t % 5 == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule